// File: doc/BRIEF.md
# Programmable Auxiliary Clock Divider

This block derives an auxiliary clock from a fast reference clock. A 6-bit divide field D sets the output period to 2·(D+1) reference cycles: the divider runs at half the reference rate and divides that rate by D+1. The result is a 50% duty output for every field value. A 2-bit mode field picks what is driven out: the divided clock, the divided clock with a reduced-drive indication, a backup clock brought in from another domain, or a constant high level.

Software may rewrite either field at any moment. Neither a new divide value nor a new mode may cut an output phase short. A new divide value is adopted only at the start of an output period. A new mode is adopted only in a cycle where the output is already high and the incoming source is just rising, so the switch adds no edge. Power-on reset clears both fields. Hard reset keeps the divide field and only clears the mode and restarts the divider. Both resets are active low and sampled on the reference clock.

Top module: `auxclk_gen`

## Requirements
- R1: In modes 00 and 01 the output has a period of 2·(D+1) reference cycles, high for D+1 cycles and low for D+1 cycles, for every D from 0 to 63.
- R2: A cycle with wr_en_i high loads wr_div_i and wr_mode_i together. The stored values appear on div_rd_o and mode_rd_o one cycle later, whether or not the output is running.
- R3: While por_n_i is low, the divide field becomes 0, the mode field becomes 00, the output is high and half_drive_o is low. Writes during this time are ignored.
- R4: While hrst_n_i is low (and por_n_i is high), the divide field keeps its value, the mode field becomes 00, the divider restarts with the output high, and writes are ignored.
- R5: Mode 01 gives the same waveform as mode 00 and sets half_drive_o high. half_drive_o is low in modes 00, 10 and 11.
- R6: In mode 10 the output follows bak_clk_i through a two-stage synchronizer and the output register, so its high and low phases match those of the backup clock.
- R7: In mode 11 the output is held high.
- R8: A new divide value is taken only when the output period restarts (divided clock going low to high). Every high or low phase therefore lasts either the old or the new D+1 cycles.
- R9: A new mode takes effect only in a cycle where the output is high and the incoming source rises. Mode 11 and changes between 00 and 01 need only a high output. No output phase is shorter than the shorter of the two sources' full phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| por_n_i | input | 1 | Power-on reset, active low, synchronous |
| hrst_n_i | input | 1 | Hard reset, active low, synchronous |
| bak_clk_i | input | 1 | Backup clock, asynchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| wr_div_i | input | 6 | Divide field write value D |
| wr_mode_i | input | 2 | Mode field write value |
| div_rd_o | output | 6 | Divide field read-back |
| mode_rd_o | output | 2 | Mode field read-back |
| aux_clk_o | output | 1 | Auxiliary clock output |
| half_drive_o | output | 1 | Reduced drive strength indication |

## Verification
Four properties are checked on every cycle: the divider counter stays within the active factor, the active factor changes only at a period restart, a mode switch happens only with the output high before and after, and the output is high whenever parked. Reset effects on the two fields are also checked each cycle. Only the bench scenarios can show the measured phase lengths. These are a full sweep of all 64 divide values with old/new tolerance at each change, backup pass-through phases, the minimum phase length across source switches, and the drive flag in each mode.

// File: rtl/auxclk_pkg.sv
package auxclk_pkg;

    localparam int DIV_W_DEF  = 6;
    localparam int SYNC_N_DEF = 2;

    typedef enum logic [1:0] {
        AUX_FULL   = 2'b00,
        AUX_HALF   = 2'b01,
        AUX_BACKUP = 2'b10,
        AUX_PARK   = 2'b11
    } aux_mode_e;

    // true when both modes drive the divided clock
    function automatic logic same_source(aux_mode_e a, aux_mode_e b);
        logic a_div;
        logic b_div;
        a_div = (a == AUX_FULL) || (a == AUX_HALF);
        b_div = (b == AUX_FULL) || (b == AUX_HALF);
        return a_div && b_div;
    endfunction

endpackage

// File: rtl/auxclk_cfg.sv
module auxclk_cfg
    import auxclk_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic             hrst_n_i,
    input  logic             wr_en_i,
    input  logic [DIV_W-1:0] wr_div_i,
    input  logic [1:0]       wr_mode_i,
    output logic [DIV_W-1:0] div_o,
    output aux_mode_e        mode_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        aux_mode_e        mode;
    } cfg_t;

    cfg_t cfg_d;
    cfg_t cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!por_n_i) begin
            cfg_d.div  = '0;
            cfg_d.mode = AUX_FULL;
        end else if (!hrst_n_i) begin
            cfg_d.mode = AUX_FULL;
        end else if (wr_en_i) begin
            cfg_d.div  = wr_div_i;
            cfg_d.mode = aux_mode_e'(wr_mode_i);
        end
    end

    always_ff @(posedge clk_i) begin
        cfg_q <= cfg_d;
    end

    assign div_o  = cfg_q.div;
    assign mode_o = cfg_q.mode;

endmodule

// File: rtl/auxclk_sync.sv
module auxclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic async_i,
    output logic sync_o,
    output logic sync_prev_o
);

    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_d;
    logic [DEPTH-1:0] chain_q;

    always_comb begin
        chain_d = chain_q;
        if (!rst_n_i) begin
            chain_d = '0;
        end else begin
            chain_d[0] = async_i;
            for (int i = 1; i < DEPTH; i++) begin
                chain_d[i] = chain_q[i-1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        chain_q <= chain_d;
    end

    // last synchronizer stage, and one more stage for edge detection
    assign sync_o      = chain_q[STAGES-1];
    assign sync_prev_o = chain_q[DEPTH-1];

endmodule

// File: rtl/auxclk_divcore.sv
module auxclk_divcore
    import auxclk_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic             hrst_n_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             div_clk_o,
    output logic [DIV_W-1:0] act_o,
    output logic [DIV_W-1:0] cnt_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] act;
        logic             ph;
    } div_t;

    div_t dv_d;
    div_t dv_q;

    logic phase_end;

    assign phase_end = (dv_q.cnt == dv_q.act);

    always_comb begin
        dv_d = dv_q;
        if (!por_n_i) begin
            dv_d.cnt = '0;
            dv_d.act = '0;
            dv_d.ph  = 1'b1;
        end else if (!hrst_n_i) begin
            dv_d.cnt = '0;
            dv_d.act = div_i;
            dv_d.ph  = 1'b1;
        end else if (phase_end) begin
            dv_d.cnt = '0;
            dv_d.ph  = ~dv_q.ph;
            // end of low phase: next period starts, adopt new factor
            if (!dv_q.ph) begin
                dv_d.act = div_i;
            end
        end else begin
            dv_d.cnt = DIV_W'(dv_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk_i) begin
        dv_q <= dv_d;
    end

    assign div_clk_o = dv_q.ph;
    assign act_o     = dv_q.act;
    assign cnt_o     = dv_q.cnt;

endmodule

// File: rtl/auxclk_outsel.sv
module auxclk_outsel
    import auxclk_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_n_i,
    input  aux_mode_e mode_i,
    input  logic      div_clk_i,
    input  logic      bak_i,
    input  logic      bak_prev_i,
    output logic      aux_o,
    output logic      half_o,
    output aux_mode_e sel_o
);

    typedef struct packed {
        aux_mode_e sel;
        logic      aux;
        logic      half;
        logic      div_prev;
    } sel_t;

    sel_t st_d;
    sel_t st_q;

    logic [3:0] src_val;
    logic [3:0] src_rise;
    logic       switch_ok;

    always_comb begin
        src_val[AUX_FULL]    = div_clk_i;
        src_val[AUX_HALF]    = div_clk_i;
        src_val[AUX_BACKUP]  = bak_i;
        src_val[AUX_PARK]    = 1'b1;
        src_rise[AUX_FULL]   = div_clk_i && !st_q.div_prev;
        src_rise[AUX_HALF]   = div_clk_i && !st_q.div_prev;
        src_rise[AUX_BACKUP] = bak_i && !bak_prev_i;
        src_rise[AUX_PARK]   = 1'b1;
    end

    always_comb begin
        switch_ok = (st_q.sel != mode_i) && st_q.aux &&
                    (same_source(st_q.sel, mode_i) || src_rise[mode_i]);
    end

    always_comb begin
        st_d          = st_q;
        st_d.div_prev = div_clk_i;
        if (!rst_n_i) begin
            st_d.sel      = AUX_FULL;
            st_d.aux      = 1'b1;
            st_d.half     = 1'b0;
            st_d.div_prev = 1'b1;
        end else begin
            if (switch_ok) begin
                st_d.sel = mode_i;
            end
            st_d.aux  = src_val[st_d.sel];
            st_d.half = (st_d.sel == AUX_HALF);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign aux_o  = st_q.aux;
    assign half_o = st_q.half;
    assign sel_o  = st_q.sel;

endmodule

// File: rtl/auxclk_gen.sv
module auxclk_gen
    import auxclk_pkg::*;
#(
    parameter int DIV_W  = DIV_W_DEF,
    parameter int SYNC_N = SYNC_N_DEF
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic             hrst_n_i,
    input  logic             bak_clk_i,
    input  logic             wr_en_i,
    input  logic [DIV_W-1:0] wr_div_i,
    input  logic [1:0]       wr_mode_i,
    output logic [DIV_W-1:0] div_rd_o,
    output logic [1:0]       mode_rd_o,
    output logic             aux_clk_o,
    output logic             half_drive_o
);

    logic             rst_all_n;
    logic [DIV_W-1:0] cfg_div;
    aux_mode_e        cfg_mode;
    logic             div_clk;
    logic [DIV_W-1:0] act_div;
    logic [DIV_W-1:0] cnt_div;
    logic             bak_s;
    logic             bak_s_prev;
    aux_mode_e        sel_mode;

    assign rst_all_n = por_n_i && hrst_n_i;

    auxclk_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk_i     (clk_i),
        .por_n_i   (por_n_i),
        .hrst_n_i  (hrst_n_i),
        .wr_en_i   (wr_en_i),
        .wr_div_i  (wr_div_i),
        .wr_mode_i (wr_mode_i),
        .div_o     (cfg_div),
        .mode_o    (cfg_mode)
    );

    auxclk_divcore #(.DIV_W(DIV_W)) u_div (
        .clk_i     (clk_i),
        .por_n_i   (por_n_i),
        .hrst_n_i  (hrst_n_i),
        .div_i     (cfg_div),
        .div_clk_o (div_clk),
        .act_o     (act_div),
        .cnt_o     (cnt_div)
    );

    auxclk_sync #(.STAGES(SYNC_N)) u_bak_sync (
        .clk_i       (clk_i),
        .rst_n_i     (rst_all_n),
        .async_i     (bak_clk_i),
        .sync_o      (bak_s),
        .sync_prev_o (bak_s_prev)
    );

    auxclk_outsel u_sel (
        .clk_i      (clk_i),
        .rst_n_i    (rst_all_n),
        .mode_i     (cfg_mode),
        .div_clk_i  (div_clk),
        .bak_i      (bak_s),
        .bak_prev_i (bak_s_prev),
        .aux_o      (aux_clk_o),
        .half_o     (half_drive_o),
        .sel_o      (sel_mode)
    );

    assign div_rd_o  = cfg_div;
    assign mode_rd_o = cfg_mode;

endmodule

// File: rtl/auxclk_gen_chk.sv
module auxclk_gen_chk #(
    parameter int DIV_W = 6
) (
    input logic             clk_i,
    input logic             por_n_i,
    input logic             hrst_n_i,
    input logic [DIV_W-1:0] div_rd_o,
    input logic [1:0]       mode_rd_o,
    input logic             aux_clk_o,
    input logic             div_clk,
    input logic [DIV_W-1:0] act_div,
    input logic [DIV_W-1:0] cnt_div,
    input logic [1:0]       sel_mode
);

    p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!por_n_i || !hrst_n_i)
        cnt_div <= act_div);

    p_por_clears_r3: assert property (@(posedge clk_i) disable iff (!hrst_n_i)
        !por_n_i |=> (div_rd_o == '0) && (mode_rd_o == 2'b00));

    p_hrst_keeps_r4: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (!hrst_n_i && $past(por_n_i)) |-> $stable(div_rd_o));

    p_park_high_r7: assert property (@(posedge clk_i) disable iff (!por_n_i || !hrst_n_i)
        (sel_mode == 2'b11) |-> aux_clk_o);

    p_act_at_rise_r8: assert property (@(posedge clk_i) disable iff (!por_n_i || !hrst_n_i)
        !$stable(act_div) |-> $rose(div_clk));

    p_switch_high_r9: assert property (@(posedge clk_i) disable iff (!por_n_i || !hrst_n_i)
        !$stable(sel_mode) |-> (aux_clk_o && $past(aux_clk_o)));

endmodule

bind auxclk_gen auxclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk_i     (clk_i),
    .por_n_i   (por_n_i),
    .hrst_n_i  (hrst_n_i),
    .div_rd_o  (div_rd_o),
    .mode_rd_o (mode_rd_o),
    .aux_clk_o (aux_clk_o),
    .div_clk   (div_clk),
    .act_div   (act_div),
    .cnt_div   (cnt_div),
    .sel_mode  (sel_mode)
);

// File: tb/tb_auxclk_gen.sv
module tb_auxclk_gen;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       hrst_n = 1'b1;
    logic       bak = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_div = '0;
    logic [1:0] wr_mode = '0;
    logic [5:0] div_rd;
    logic [1:0] mode_rd;
    logic       aux;
    logic       half;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    auxclk_gen dut (
        .clk_i        (clk),
        .por_n_i      (por_n),
        .hrst_n_i     (hrst_n),
        .bak_clk_i    (bak),
        .wr_en_i      (wr_en),
        .wr_div_i     (wr_div),
        .wr_mode_i    (wr_mode),
        .div_rd_o     (div_rd),
        .mode_rd_o    (mode_rd),
        .aux_clk_o    (aux),
        .half_drive_o (half)
    );

    // backup clock: 5 cycles high, 5 cycles low
    initial begin
        forever begin
            repeat (5) @(negedge clk);
            bak = ~bak;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic check_two(input string tag, input int got, input int a, input int b);
        checks++;
        if (got != a && got != b) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d or %0d", tag, got, a, b);
        end
    endtask

    task automatic check_min(input string tag, input int got, input int lo);
        checks++;
        if (got < lo) begin
            fails++;
            $display("FAIL %s got=%0d expected>=%0d", tag, got, lo);
        end
    endtask

    task automatic write(input int d, input int m);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_div  = 6'(d);
        wr_mode = 2'(m);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sync_edge();
        logic lvl;
        lvl = aux;
        while (aux == lvl) @(negedge clk);
    endtask

    task automatic run_len(output int n);
        logic lvl;
        lvl = aux;
        n = 0;
        while (aux == lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int prev;
        int lows;
        // R3: power-on reset state
        repeat (4) @(negedge clk);
        check("R3 aux in por", int'(aux), 1);
        check("R3 half in por", int'(half), 0);
        check("R3 div in por", int'(div_rd), 0);
        check("R3 mode in por", int'(mode_rd), 0);
        @(negedge clk);
        por_n = 1'b1;
        sync_edge();
        run_len(n); check("R1 D=0 phase", n, 1);
        run_len(n); check("R1 D=0 phase", n, 1);

        // R1 / R2 / R8: sweep all factors, then large jumps
        prev = 0;
        for (int k = 1; k < 67; k++) begin
            int d;
            d = (k < 64) ? k : ((k == 64) ? 0 : ((k == 65) ? 63 : 5));
            write(d, 0);
            check("R2 div readback", int'(div_rd), d);
            check("R2 mode readback", int'(mode_rd), 0);
            sync_edge();
            for (int r = 0; r < 4; r++) begin
                run_len(n); check_two("R8 phase old/new", n, prev + 1, d + 1);
            end
            run_len(n); check("R1 high/low phase", n, d + 1);
            run_len(n); check("R1 high/low phase", n, d + 1);
            prev = d;
        end

        // R4: hard reset keeps divide field, writes ignored during it
        write(9, 0);
        repeat (40) @(negedge clk);
        hrst_n  = 1'b0;
        wr_en   = 1'b1;
        wr_div  = 6'd20;
        wr_mode = 2'b11;
        repeat (3) @(negedge clk);
        check("R4 aux high in hrst", int'(aux), 1);
        wr_en  = 1'b0;
        hrst_n = 1'b1;
        @(negedge clk);
        check("R4 div kept", int'(div_rd), 9);
        check("R4 mode cleared", int'(mode_rd), 0);
        sync_edge();
        run_len(n); check("R4 phase after hrst", n, 10);
        run_len(n); check("R4 phase after hrst", n, 10);

        // R5: reduced drive mode
        write(9, 1);
        check("R2 mode readback", int'(mode_rd), 1);
        repeat (60) @(negedge clk);
        check("R5 half flag in 01", int'(half), 1);
        sync_edge();
        run_len(n); check("R5 phase in 01", n, 10);
        run_len(n); check("R5 phase in 01", n, 10);

        // R6: backup pass-through
        write(9, 2);
        repeat (80) @(negedge clk);
        check("R6 half flag in 10", int'(half), 0);
        sync_edge();
        for (int r = 0; r < 4; r++) begin
            run_len(n); check("R6 backup phase", n, 5);
        end

        // R9: backup -> divided (D=6), no phase shorter than 5
        write(6, 0);
        sync_edge();
        for (int r = 0; r < 8; r++) begin
            run_len(n); check_min("R9 no short phase", n, 5);
        end
        repeat (60) @(negedge clk);
        sync_edge();
        run_len(n); check("R9 settled phase", n, 7);
        check("R5 half flag in 00", int'(half), 0);

        // R7: park high
        write(6, 3);
        repeat (40) @(negedge clk);
        lows = 0;
        for (int c = 0; c < 200; c++) begin
            if (!aux) lows++;
            @(negedge clk);
        end
        check("R7 low samples in 11", lows, 0);
        check("R7 half flag in 11", int'(half), 0);

        // R9: park -> divided D=3, first low phase is full
        write(3, 0);
        sync_edge();
        check("R9 fell from park", int'(aux), 0);
        run_len(n); check("R9 first low after park", n, 4);
        run_len(n); check("R9 first high after park", n, 4);

        // R3: power-on reset mid-run clears both fields
        write(20, 2);
        repeat (30) @(negedge clk);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check("R3 div cleared", int'(div_rd), 0);
        check("R3 mode cleared", int'(mode_rd), 0);
        sync_edge();
        run_len(n); check("R3 phase after por", n, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule